// File: doc/BRIEF.md
# Multiply-Permute Keyed Hash Absorber

This block keeps the 1024-bit working state of a keyed hash. The state is four 256-bit vectors: two accumulators and two multiply-feedback words. Each vector is split into four independent 64-bit lanes. A start pulse seeds the state from a 256-bit key and two fixed 256-bit constants. After that, each 32-byte packet accepted on a valid/ready handshake is folded into the state. The fold uses lane-wise addition, unsigned 32x32 multiplication, XOR and a fixed byte interleave that pairs neighbouring lanes.

A round takes two clock cycles. The first cycle does the additions and both multiplies. The second cycle does the two interleave-and-add steps. Ready stays low during the second cycle. The four state vectors are driven straight to the ports for a downstream finalizer. They hold a finished state whenever ready is high and start is low. A new key can be loaded at any time, including in the middle of a round.

Top module: `mpk_absorber`

## Requirements
- R1: While reset is high and after its release, all four state outputs are zero and `pkt_ready` is high.
- R2: One cycle after a `start` pulse, `acc_a` equals key XOR `SEED_A`, and `acc_b` equals (key with the two 32-bit halves of each 64-bit lane swapped) XOR `SEED_B`. Also `fb_a` equals `SEED_A` and `fb_b` equals `SEED_B`.
- R3: A packet is accepted on a rising edge where `pkt_valid` and `pkt_ready` are both high. Two edges later the state equals one update of the previous state. Packet bits [64i+63:64i] feed lane i, so byte 0 is the least significant byte of lane 0. The update runs in this order: `acc_b += pkt`; `acc_b += fb_a`; `fb_a ^= lo32(acc_b)*hi32(acc_a)`; `acc_a += fb_b`; `fb_b ^= lo32(acc_a)*hi32(acc_b)`; `acc_a += Z(acc_b)`; `acc_b += Z(acc_a)`.
- R4: The interleave Z works on each pair of lanes (2k, 2k+1), viewed as 16 bytes numbered 0 to 15 from the bottom of lane 2k. Result bytes 15 down to 0 take source bytes 7,8,6,9,13,10,4,11,0,15,1,14,5,2,12,3.
- R5: `pkt_ready` is low in the cycle after an acceptance and high again in the cycle after that.
- R6: While `pkt_ready` is low, a valid packet is not absorbed. While idle with `pkt_valid` low, the state holds.
- R7: When `start` is high, `pkt_ready` is low and the key load wins: a packet offered in that cycle is not absorbed.
- R8: Additions are modulo 2^64 per lane with no carry between lanes. Products are unsigned, so all-ones operands give 0xFFFFFFFE00000001.
- R9: Back-to-back packets are absorbed in the order they are accepted.
- R10: A `start` during the second cycle of a round drops that round and loads the new key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the state from `key` |
| key | input | 256 | Hash key |
| pkt_valid | input | 1 | Packet offered |
| pkt_data | input | 256 | 32-byte packet, lane 0 in bits [63:0] |
| pkt_ready | output | 1 | Block can accept a packet |
| acc_a | output | 256 | First accumulator vector |
| acc_b | output | 256 | Second accumulator vector |
| fb_a | output | 256 | First multiply-feedback vector |
| fb_b | output | 256 | Second multiply-feedback vector |

## Verification
The bench drives a sweep of 32 packets, each with a single non-zero byte at a different position. A wrong interleave entry or a byte-order mix-up would then corrupt a state byte that can be seen at the ports. All-ones keys and packets test the per-lane carry and the unsigned multiply. A design that lets a carry cross lanes, or that treats the operands as signed, would give wrong lane values. The bench also offers packets while ready is low, together with start, and right after a round has begun. A design that absorbed those packets, or that finished the round after start, would end in a state that differs from the key-only or single-packet model.

// File: rtl/mpk_pkg.sv
package mpk_pkg;

    localparam int LANE_W    = 64;
    localparam int NUM_LANES = 4;
    localparam int HALF_W    = LANE_W / 2;
    localparam int VEC_W     = LANE_W * NUM_LANES;
    localparam int PAIR_B    = 2 * LANE_W / 8;

    typedef logic [LANE_W-1:0]                 lane_t;
    typedef logic [NUM_LANES-1:0][LANE_W-1:0]  vec_t;

    typedef struct packed {
        vec_t fb_b;
        vec_t fb_a;
        vec_t acc_b;
        vec_t acc_a;
    } state_t;

    typedef enum logic {PH_IDLE, PH_MIX} phase_e;

    // Lane-wise add, no carry between lanes
    function automatic vec_t vadd(input vec_t x, input vec_t y);
        vec_t r;
        for (int i = 0; i < NUM_LANES; i++) r[i] = x[i] + y[i];
        return r;
    endfunction

    // Swap the 32-bit halves of every lane
    function automatic vec_t vswap(input vec_t x);
        vec_t r;
        for (int i = 0; i < NUM_LANES; i++) r[i] = {x[i][HALF_W-1:0], x[i][LANE_W-1:HALF_W]};
        return r;
    endfunction

    // Source byte index for each result byte of a lane pair
    function automatic int unsigned zip_src(input int unsigned dst);
        case (dst)
            0:  zip_src = 3;
            1:  zip_src = 12;
            2:  zip_src = 2;
            3:  zip_src = 5;
            4:  zip_src = 14;
            5:  zip_src = 1;
            6:  zip_src = 15;
            7:  zip_src = 0;
            8:  zip_src = 11;
            9:  zip_src = 4;
            10: zip_src = 10;
            11: zip_src = 13;
            12: zip_src = 9;
            13: zip_src = 6;
            14: zip_src = 8;
            default: zip_src = 7;
        endcase
    endfunction

endpackage

// File: rtl/mpk_mul_mix.sv
module mpk_mul_mix
    import mpk_pkg::*;
(
    input  vec_t acc_in,
    input  vec_t lo_src,
    input  vec_t hi_src,
    output vec_t acc_out
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [HALF_W-1:0] op_lo;
        logic [HALF_W-1:0] op_hi;
        lane_t             prod;
        assign op_lo = lo_src[g][HALF_W-1:0];
        assign op_hi = hi_src[g][LANE_W-1:HALF_W];
        assign prod  = LANE_W'(op_lo) * LANE_W'(op_hi);
        assign acc_out[g] = acc_in[g] ^ prod;
    end
endmodule

// File: rtl/mpk_zipper.sv
module mpk_zipper
    import mpk_pkg::*;
(
    input  vec_t src,
    output vec_t dst
);
    localparam int NUM_PAIRS = NUM_LANES / 2;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic [2*LANE_W-1:0] s_pair;
        logic [2*LANE_W-1:0] d_pair;
        assign s_pair = {src[2*p+1], src[2*p]};
        for (genvar b = 0; b < PAIR_B; b++) begin : g_byte
            localparam int unsigned SB = zip_src(b);
            assign d_pair[8*b +: 8] = s_pair[8*SB +: 8];
        end
        assign dst[2*p]   = d_pair[LANE_W-1:0];
        assign dst[2*p+1] = d_pair[2*LANE_W-1:LANE_W];
    end
endmodule

// File: rtl/mpk_absorber.sv
module mpk_absorber
    import mpk_pkg::*;
#(
    parameter logic [VEC_W-1:0] SEED_A = 256'hdbe6d5d5fe4cce2f_a4093822299f31d0_13198a2e03707344_243f6a8885a308d3,
    parameter logic [VEC_W-1:0] SEED_B = 256'h3bd39e10cb0ef593_c0acf169b5f18a8c_be5466cf34e90c6c_452821e638d01377
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VEC_W-1:0] key,
    input  logic             pkt_valid,
    input  logic [VEC_W-1:0] pkt_data,
    output logic             pkt_ready,
    output logic [VEC_W-1:0] acc_a,
    output logic [VEC_W-1:0] acc_b,
    output logic [VEC_W-1:0] fb_a,
    output logic [VEC_W-1:0] fb_b
);
    state_t st;
    phase_e phase;
    logic   accept;

    vec_t pkt_v, key_v;
    vec_t a_acc_b, a_fb_a, a_acc_a, a_fb_b;
    vec_t zb, b_acc_a, za, b_acc_b;

    assign pkt_v  = vec_t'(pkt_data);
    assign key_v  = vec_t'(key);
    assign pkt_ready = (phase == PH_IDLE) && !start;
    assign accept = pkt_valid && pkt_ready;

    // First half: additions and both multiplies
    assign a_acc_b = vadd(vadd(st.acc_b, pkt_v), st.fb_a);

    mpk_mul_mix i_mul_first (
        .acc_in (st.fb_a),
        .lo_src (a_acc_b),
        .hi_src (st.acc_a),
        .acc_out(a_fb_a)
    );

    assign a_acc_a = vadd(st.acc_a, st.fb_b);

    mpk_mul_mix i_mul_second (
        .acc_in (st.fb_b),
        .lo_src (a_acc_a),
        .hi_src (a_acc_b),
        .acc_out(a_fb_b)
    );

    // Second half: interleave and add, chained
    mpk_zipper i_zip_b (
        .src(st.acc_b),
        .dst(zb)
    );
    assign b_acc_a = vadd(st.acc_a, zb);

    mpk_zipper i_zip_a (
        .src(b_acc_a),
        .dst(za)
    );
    assign b_acc_b = vadd(st.acc_b, za);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            phase <= PH_IDLE;
        end else if (start) begin
            st.acc_a <= key_v ^ vec_t'(SEED_A);
            st.acc_b <= vswap(key_v) ^ vec_t'(SEED_B);
            st.fb_a  <= vec_t'(SEED_A);
            st.fb_b  <= vec_t'(SEED_B);
            phase    <= PH_IDLE;
        end else if (phase == PH_MIX) begin
            st.acc_a <= b_acc_a;
            st.acc_b <= b_acc_b;
            phase    <= PH_IDLE;
        end else if (accept) begin
            st.acc_a <= a_acc_a;
            st.acc_b <= a_acc_b;
            st.fb_a  <= a_fb_a;
            st.fb_b  <= a_fb_b;
            phase    <= PH_MIX;
        end
    end

    assign acc_a = VEC_W'(st.acc_a);
    assign acc_b = VEC_W'(st.acc_b);
    assign fb_a  = VEC_W'(st.fb_a);
    assign fb_b  = VEC_W'(st.fb_b);

    // R7
    start_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !pkt_ready);

    // R2
    key_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (fb_a == SEED_A) && (fb_b == SEED_B) && (acc_a == ($past(key) ^ SEED_A)));

    // R5
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready) |=> !pkt_ready);

    // R5
    round_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (!pkt_ready && !start) |=> (pkt_ready || start));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_ready && !pkt_valid) |=> $stable(acc_a) && $stable(acc_b) && $stable(fb_a) && $stable(fb_b));

    // R6
    fb_hold_in_mix_chk: assert property (@(posedge clk) disable iff (rst)
        (!pkt_ready && !start) |=> $stable(fb_a) && $stable(fb_b));

endmodule

// File: tb/test_mpk_absorber.sv
module test_mpk_absorber;
    localparam int CLK_P = 10;
    localparam logic [255:0] SA = 256'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0_1122334455667788_99aabbccddeeff00;
    localparam logic [255:0] SB = 256'hfedcba9876543210_0123456789abcdef_a5a55a5a3c3cc3c3_deadbeefcafef00d;
    localparam int ZS [16] = '{3, 12, 2, 5, 14, 1, 15, 0, 11, 4, 10, 13, 9, 6, 8, 7};

    logic clk = 0, rst = 1, start = 0, pkt_valid = 0;
    logic [255:0] key = '0, pkt_data = '0;
    logic pkt_ready;
    logic [255:0] acc_a, acc_b, fb_a, fb_b;
    logic [255:0] ma, mb, mfa, mfb;
    int n_run = 0, n_fail = 0, cycles = 0;

    mpk_absorber #(.SEED_A(SA), .SEED_B(SB)) i_mpk_absorber (
        .clk(clk), .rst(rst), .start(start), .key(key),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ready(pkt_ready),
        .acc_a(acc_a), .acc_b(acc_b), .fb_a(fb_a), .fb_b(fb_b)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    function automatic logic [255:0] f_add(input logic [255:0] x, input logic [255:0] y);
        logic [255:0] r;
        for (int i = 0; i < 4; i++) r[64*i +: 64] = x[64*i +: 64] + y[64*i +: 64];
        return r;
    endfunction

    function automatic logic [255:0] f_mix(input logic [255:0] c, input logic [255:0] lo, input logic [255:0] hi);
        logic [255:0] r;
        for (int i = 0; i < 4; i++) begin
            logic [63:0] x, y;
            x = {32'd0, lo[64*i +: 32]};
            y = {32'd0, hi[64*i+32 +: 32]};
            r[64*i +: 64] = c[64*i +: 64] ^ (x * y);
        end
        return r;
    endfunction

    function automatic logic [255:0] f_zip(input logic [255:0] v);
        logic [255:0] r;
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 16; i++)
                r[128*p + 8*i +: 8] = v[128*p + 8*ZS[i] +: 8];
        return r;
    endfunction

    task automatic m_init(input logic [255:0] k);
        ma = k ^ SA;
        for (int i = 0; i < 4; i++) mb[64*i +: 64] = {k[64*i +: 32], k[64*i+32 +: 32]} ^ SB[64*i +: 64];
        mfa = SA;
        mfb = SB;
    endtask

    task automatic m_update(input logic [255:0] p);
        mb  = f_add(f_add(mb, p), mfa);
        mfa = f_mix(mfa, mb, ma);
        ma  = f_add(ma, mfb);
        mfb = f_mix(mfb, ma, mb);
        ma  = f_add(ma, f_zip(mb));
        mb  = f_add(mb, f_zip(ma));
    endtask

    task automatic chk(input string tag, input logic [1023:0] act, input logic [1023:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, {fb_b, fb_a, acc_b, acc_a}, {mfb, mfa, mb, ma});
    endtask

    task automatic load_key(input logic [255:0] k);
        @(negedge clk); start = 1; key = k;
        @(negedge clk); start = 0;
        m_init(k);
    endtask

    // drives at negedge; returns at the negedge after the round ends
    task automatic send(input logic [255:0] p);
        @(negedge clk); pkt_valid = 1; pkt_data = p;
        @(negedge clk); pkt_valid = 0;
        @(negedge clk);
        m_update(p);
    endtask

    initial begin
        logic [255:0] lcg;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 reset state", {fb_b, fb_a, acc_b, acc_a, 1023'd0} >> 1023, {1'b0});
        chk("R1 state zero", {fb_b, fb_a, acc_b, acc_a}, '0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk("R1 ready after reset", {1023'd0, pkt_ready}, 1024'd1);

        // R2
        load_key(256'h0123456789abcdef_fedcba9876543210_00000000ffffffff_ffffffff00000000);
        chk_state("R2 key load");

        // R4 R3: single byte sweep over all packet positions, zero key
        load_key('0);
        for (int b = 0; b < 32; b++) begin
            send(256'(8'h80 | 8'(b)) << (8 * b));
            chk_state($sformatf("R4 R3 byte sweep %0d", b));
        end

        // R8: all-ones key and packets
        load_key('1);
        chk_state("R8 ones key");
        send('1);
        chk_state("R8 ones packet 1");
        send('1);
        chk_state("R8 ones packet 2");

        // R9: back-to-back distinct packets
        load_key(256'h5555aaaa_3333cccc_0f0ff0f0_12345678_9abcdef0_13579bdf_2468ace0_87654321);
        lcg = 256'h1;
        for (int n = 0; n < 8; n++) begin
            lcg = lcg * 256'd6364136223846793005 + 256'd1442695040888963407;
            send(lcg);
            chk_state($sformatf("R9 sequence %0d", n));
        end

        // R5 R6: packet offered while the round is busy
        @(negedge clk); pkt_valid = 1; pkt_data = 256'habcdef;
        @(negedge clk); pkt_data = 256'h999999;
        chk("R5 ready low mid round", {1023'd0, pkt_ready}, 1024'd0);
        @(negedge clk); pkt_valid = 0;
        m_update(256'habcdef);
        chk("R5 ready high after round", {1023'd0, pkt_ready}, 1024'd1);
        chk_state("R6 busy packet ignored");
        repeat (3) @(negedge clk);
        chk_state("R6 idle hold");

        // R7: start and valid together
        @(negedge clk); start = 1; key = 256'h77; pkt_valid = 1; pkt_data = 256'h4242;
        #1 chk("R7 ready low with start", {1023'd0, pkt_ready}, 1024'd0);
        @(negedge clk); start = 0; pkt_valid = 0;
        m_init(256'h77);
        chk_state("R7 start wins");

        // R10: start during second half of a round
        @(negedge clk); pkt_valid = 1; pkt_data = 256'h31337;
        @(negedge clk); pkt_valid = 0; start = 1; key = 256'hc0ffee;
        @(negedge clk); start = 0;
        m_init(256'hc0ffee);
        chk_state("R10 abort reloads");
        send(256'h1);
        chk_state("R10 round after abort");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule